// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block is the address sequencer of a single DMA channel. A transfer block is made of a number of frames, and each frame is made of a number of elements. For every element the block presents a source address and a destination address. A consumer moves the data for that element and then accepts it with a one-cycle acknowledge. The sequencer then steps both addresses and its element and frame counters.

The configuration is sampled when a start pulse arrives while the generator is idle. It covers the two base addresses, the element and frame counts, the element size and a separate addressing mode for each side. It also covers signed element and frame index strides for each side. The counts and strides stay fixed for the whole block. Each address side follows its own mode: constant, post-increment, single index or double index. The block emits one-cycle event pulses for half frame, frame end, start of the last frame and block end, plus a done pulse. A stop input abandons a transfer at any time.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset the generator is idle. busy is 0, both addresses are 0 and every event and done output is 0.
- R2: A start pulse while idle, with a nonzero element count and a nonzero frame count, loads the configuration. In the next cycle busy is 1 and the addresses equal the two base addresses. A start with either count zero is ignored, and so is a start while busy.
- R3: The generator advances only on a clock edge where busy and ack are both 1. Without ack the addresses hold and the counters stay put. An ack while idle has no effect.
- R4: Mode code 0 (constant) keeps that side's address unchanged across accepted elements.
- R5: Mode code 1 (post-increment) adds the element size in bytes after each accepted element. The size code is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes.
- R6: Mode code 2 (single index) adds the element size in bytes plus (element index − 1). The index is a signed two's-complement value.
- R7: Mode code 3 (double index) behaves like mode 2, except after the last element of a frame. There it adds the element size plus (frame index − 1), with the frame index signed.
- R8: frame_end is a one-cycle pulse in the cycle after the last element of any frame is accepted.
- R9: When the element count is at least 2, half_frame is a one-cycle pulse in the cycle after element number floor(count/2) of a frame is accepted. Elements are numbered from 1.
- R10: last_frame_start is a one-cycle pulse in the first cycle in which the first element of the last frame is presented. For a one-frame block, this is the cycle right after start.
- R11: After exactly count×frames accepted elements, block_end and done pulse together for one cycle, and busy is 0 in that same cycle.
- R12: stop while busy returns the generator to idle in the next cycle without a block_end or done pulse.
- R13: The source and destination sides use their own modes and strides independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, used while idle |
| stop | input | 1 | Abandon the current transfer |
| ack | input | 1 | Current element accepted |
| src_base | input | AW | Source start address |
| dst_base | input | AW | Destination start address |
| elem_count | input | ECW | Elements per frame |
| frame_count | input | FCW | Frames per block |
| elem_size | input | 2 | Element size code |
| src_mode | input | 2 | Source addressing mode |
| dst_mode | input | 2 | Destination addressing mode |
| src_eidx | input | IW | Source element stride (signed) |
| src_fidx | input | IW | Source frame stride (signed) |
| dst_eidx | input | IW | Destination element stride (signed) |
| dst_fidx | input | IW | Destination frame stride (signed) |
| busy | output | 1 | Transfer in progress, addresses valid |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| half_frame | output | 1 | Half-frame event pulse |
| frame_end | output | 1 | Frame-complete event pulse |
| last_frame_start | output | 1 | Last-frame-start event pulse |
| block_end | output | 1 | Block-complete event pulse |
| done | output | 1 | Transfer finished pulse |

## Verification
The bench targets the following corner cases:

- **Double-index frame boundary.** It runs negative frame and element strides. A design that used the element stride at a frame boundary, or treated a stride as unsigned, would drift off the expected address at the first new frame.
- **Single-element, single-frame block.** The last-frame pulse must coincide with the first element, and done must follow the only acknowledge. An off-by-one counter would either run an extra element or never raise done.
- **Stalls without acknowledge.** The bench inserts stalls and checks that event pulses last exactly one cycle and that addresses freeze.
- **Ignored commands.** It issues starts with zero counts, starts while busy, acks while idle and a stop mid-block. Each is checked at the address and status ports, so a design that reloaded or advanced on these commands is caught.

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int AW  = 32,
  parameter int ECW = 24,
  parameter int FCW = 16,
  parameter int IW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           stop,
  input  logic           ack,
  input  logic [AW-1:0]  src_base,
  input  logic [AW-1:0]  dst_base,
  input  logic [ECW-1:0] elem_count,
  input  logic [FCW-1:0] frame_count,
  input  logic [1:0]     elem_size,
  input  logic [1:0]     src_mode,
  input  logic [1:0]     dst_mode,
  input  logic [IW-1:0]  src_eidx,
  input  logic [IW-1:0]  src_fidx,
  input  logic [IW-1:0]  dst_eidx,
  input  logic [IW-1:0]  dst_fidx,
  output logic           busy,
  output logic [AW-1:0]  src_addr,
  output logic [AW-1:0]  dst_addr,
  output logic           half_frame,
  output logic           frame_end,
  output logic           last_frame_start,
  output logic           block_end,
  output logic           done
);

  localparam logic [1:0] M_CONST = 2'd0;
  localparam logic [1:0] M_INC   = 2'd1;
  localparam logic [1:0] M_DBL   = 2'd3;

  logic [ECW-1:0] en_q, e_q;
  logic [FCW-1:0] fn_q, f_q;
  logic [1:0]     sz_q, smode_q, dmode_q;
  logic [IW-1:0]  sei_q, sfi_q, dei_q, dfi_q;
  logic [AW-1:0]  nbytes, src_nxt, dst_nxt;
  logic           last_e, last_f, go;

  assign last_e = (e_q == en_q);
  assign last_f = (f_q == fn_q);
  assign go     = start && (elem_count != '0) && (frame_count != '0);
  assign nbytes = (sz_q == 2'd0) ? AW'(1) : (sz_q == 2'd1) ? AW'(2) : AW'(4);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] m,
                                         input logic [IW-1:0] ei, input logic [IW-1:0] fi,
                                         input logic frame_last, input logic [AW-1:0] nb);
    logic [AW-1:0] ix;
    ix = (m == M_DBL && frame_last) ? AW'($signed(fi)) : AW'($signed(ei));
    case (m)
      M_CONST: step = a;
      M_INC:   step = a + nb;
      default: step = a + nb + ix - AW'(1);
    endcase
  endfunction

  assign src_nxt = step(src_addr, smode_q, sei_q, sfi_q, last_e, nbytes);
  assign dst_nxt = step(dst_addr, dmode_q, dei_q, dfi_q, last_e, nbytes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      src_addr <= '0;  dst_addr <= '0;
      e_q <= '0;  f_q <= '0;  en_q <= '0;  fn_q <= '0;
      sz_q <= '0;  smode_q <= '0;  dmode_q <= '0;
      sei_q <= '0;  sfi_q <= '0;  dei_q <= '0;  dfi_q <= '0;
      half_frame <= 1'b0;  frame_end <= 1'b0;  last_frame_start <= 1'b0;
      block_end <= 1'b0;  done <= 1'b0;
    end else begin
      half_frame <= 1'b0;  frame_end <= 1'b0;  last_frame_start <= 1'b0;
      block_end <= 1'b0;  done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy <= 1'b1;
          en_q <= elem_count;  fn_q <= frame_count;
          sz_q <= elem_size;  smode_q <= src_mode;  dmode_q <= dst_mode;
          sei_q <= src_eidx;  sfi_q <= src_fidx;  dei_q <= dst_eidx;  dfi_q <= dst_fidx;
          src_addr <= src_base;  dst_addr <= dst_base;
          e_q <= ECW'(1);  f_q <= FCW'(1);
          last_frame_start <= (frame_count == FCW'(1));
        end
      end else if (stop) begin
        busy <= 1'b0;
      end else if (ack) begin
        half_frame <= (en_q > ECW'(1)) && (e_q == (en_q >> 1));
        frame_end  <= last_e;
        if (last_e && last_f) begin
          busy <= 1'b0;  block_end <= 1'b1;  done <= 1'b1;
        end else begin
          src_addr <= src_nxt;
          dst_addr <= dst_nxt;
          if (last_e) begin
            e_q <= ECW'(1);
            f_q <= f_q + FCW'(1);
            last_frame_start <= (f_q == fn_q - FCW'(1));
          end else begin
            e_q <= e_q + ECW'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW  = 32,
  parameter int ECW = 24,
  parameter int FCW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           stop,
  input logic           ack,
  input logic [AW-1:0]  src_base,
  input logic [AW-1:0]  dst_base,
  input logic [ECW-1:0] elem_count,
  input logic [FCW-1:0] frame_count,
  input logic [1:0]     smode_q,
  input logic           busy,
  input logic [AW-1:0]  src_addr,
  input logic [AW-1:0]  dst_addr,
  input logic           half_frame,
  input logic           frame_end,
  input logic           block_end,
  input logic           done
);

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && elem_count != '0 && frame_count != '0 |=>
      busy && src_addr == $past(src_base) && dst_addr == $past(dst_base)); // R2

  AST_ZERO_COUNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (elem_count == '0 || frame_count == '0) |=> !busy); // R2

  AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ack |=> $stable(src_addr) && $stable(dst_addr)); // R3

  AST_CONST_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ack && smode_q == 2'd0 |=> $stable(src_addr)); // R4

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({half_frame, frame_end})); // R9

  AST_DONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> block_end && frame_end && !busy); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_STOP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && stop |=> !busy && !done && !block_end); // R12

endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW), .ECW(ECW), .FCW(FCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .ack(ack),
  .src_base(src_base), .dst_base(dst_base), .elem_count(elem_count),
  .frame_count(frame_count), .smode_q(smode_q), .busy(busy),
  .src_addr(src_addr), .dst_addr(dst_addr), .half_frame(half_frame),
  .frame_end(frame_end), .block_end(block_end), .done(done)
);

// File: tb/dma2d_addr_gen_tb.sv
module dma2d_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0, ack = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0;
  logic [23:0] elem_count = '0;
  logic [15:0] frame_count = '0;
  logic [1:0]  elem_size = '0, src_mode = '0, dst_mode = '0;
  logic [15:0] src_eidx = '0, src_fidx = '0, dst_eidx = '0, dst_fidx = '0;
  logic        busy, half_frame, frame_end, last_frame_start, block_end, done;
  logic [31:0] src_addr, dst_addr;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dma2d_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .ack(ack),
    .src_base(src_base), .dst_base(dst_base), .elem_count(elem_count),
    .frame_count(frame_count), .elem_size(elem_size), .src_mode(src_mode),
    .dst_mode(dst_mode), .src_eidx(src_eidx), .src_fidx(src_fidx),
    .dst_eidx(dst_eidx), .dst_fidx(dst_fidx), .busy(busy),
    .src_addr(src_addr), .dst_addr(dst_addr), .half_frame(half_frame),
    .frame_end(frame_end), .last_frame_start(last_frame_start),
    .block_end(block_end), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] a, input logic [1:0] m,
                                      input logic [1:0] sz, input int ei, input int fi,
                                      input bit lastf);
    int nb;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    case (m)
      2'd0: return a;
      2'd1: return a + 32'(nb);
      2'd2: return a + 32'(nb + ei - 1);
      default: return a + 32'(nb + (lastf ? fi : ei) - 1);
    endcase
  endfunction

  task automatic run(input string tag, input int en, input int fn, input logic [1:0] sz,
                     input logic [1:0] sm, input logic [1:0] dm, input int sei, input int sfi,
                     input int dei, input int dfi, input logic [31:0] sb, input logic [31:0] db,
                     input bit stall);
    logic [31:0] es, ed;
    int pe;
    bit pv;
    @(negedge clk);
    src_base = sb; dst_base = db; elem_count = 24'(en); frame_count = 16'(fn);
    elem_size = sz; src_mode = sm; dst_mode = dm;
    src_eidx = 16'(sei); src_fidx = 16'(sfi); dst_eidx = 16'(dei); dst_fidx = 16'(dfi);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    es = sb; ed = db; pv = 0; pe = 0;
    for (int f = 1; f <= fn; f++) begin
      for (int e = 1; e <= en; e++) begin
        chk({"R2 busy ", tag}, 32'(busy), 32'd1);
        chk({"R13 src addr ", tag}, src_addr, es);
        chk({"R13 dst addr ", tag}, dst_addr, ed);
        chk({"R8 frame_end ", tag}, 32'(frame_end), 32'(pv && pe == en));
        chk({"R9 half_frame ", tag}, 32'(half_frame), 32'(pv && en > 1 && pe == en / 2));
        chk({"R10 last_frame_start ", tag}, 32'(last_frame_start), 32'(e == 1 && f == fn));
        chk({"R11 done early ", tag}, 32'(done), 32'd0);
        if (stall && (e % 2 == 0)) begin
          @(negedge clk);
          chk({"R3 stall src ", tag}, src_addr, es);
          chk({"R3 stall dst ", tag}, dst_addr, ed);
          chk({"R8 pulse width ", tag},
              32'({frame_end, half_frame, last_frame_start, done}), 32'd0);
        end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        pv = 1; pe = e;
        es = nxt(es, sm, sz, sei, sfi, e == en);
        ed = nxt(ed, dm, sz, dei, dfi, e == en);
      end
    end
    chk({"R11 done ", tag}, 32'(done), 32'd1);
    chk({"R11 block_end ", tag}, 32'(block_end), 32'd1);
    chk({"R8 final frame_end ", tag}, 32'(frame_end), 32'd1);
    chk({"R11 busy low ", tag}, 32'(busy), 32'd0);
    @(negedge clk);
    chk({"R11 done one cycle ", tag}, 32'(done), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 src", src_addr, 32'd0);
    chk("R1 dst", dst_addr, 32'd0);
    chk("R1 events", 32'({half_frame, frame_end, last_frame_start, block_end, done}), 32'd0);
  endtask

  task automatic t_zero_counts;
    @(negedge clk);
    src_base = 32'h5000; elem_count = '0; frame_count = 16'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 zero elem count ignored", 32'(busy), 32'd0);
    elem_count = 24'd3; frame_count = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 zero frame count ignored", 32'(busy), 32'd0);
  endtask

  task automatic t_busy_start_stop_idle_ack;
    logic [31:0] hold_s, hold_d;
    @(negedge clk);
    src_base = 32'h100; dst_base = 32'h200; elem_count = 24'd8; frame_count = 16'd4;
    elem_size = 2'd2; src_mode = 2'd1; dst_mode = 2'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R5 post-inc src", src_addr, 32'h104);
    src_base = 32'hAAAA0; dst_base = 32'hBBBB0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 start while busy ignored", src_addr, 32'h104);
    chk("R2 start while busy dst", dst_addr, 32'h204);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R12 stop idles", 32'(busy), 32'd0);
    chk("R12 no done", 32'({done, block_end}), 32'd0);
    hold_s = src_addr; hold_d = dst_addr;
    ack = 1'b1;
    repeat (3) @(negedge clk);
    ack = 1'b0;
    chk("R3 idle ack busy", 32'(busy), 32'd0);
    chk("R3 idle ack src", src_addr, hold_s);
    chk("R3 idle ack dst", dst_addr, hold_d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // R4 R5: post-increment source, constant destination, 32-bit elements
    run("inc/const", 4, 3, 2'd2, 2'd1, 2'd0, 1, 1, 1, 1, 32'h1000, 32'h8000, 0);
    // R6 R7 R13: single index source, double index destination with negative strides, stalls
    run("sidx/didx", 5, 2, 2'd1, 2'd2, 2'd3, 3, 1, -2, -9, 32'h2000, 32'h9000, 1);
    // R10 R11: one element, one frame
    run("single", 1, 1, 2'd0, 2'd1, 2'd1, 1, 1, 1, 1, 32'h30, 32'h40, 0);
    // R7 R9: double index on source with odd count, 8-bit elements
    run("didx8", 3, 4, 2'd0, 2'd3, 2'd2, 2, -5, 4, 1, 32'h4000, 32'h6000, 1);
    t_zero_counts();
    t_busy_start_stop_idle_ack();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule